// File: doc/BRIEF.md
# Flagged-Sample Concealment Filter

This block sits after the error-correction stage of a digital audio path. Each incoming 16-bit sample comes with a flag that marks it as damaged beyond repair upstream. The block hides those damaged samples, so they do not reach the converter as clicks or bursts.

Samples pass through a four-entry delay line. While a sample waits there, the block can see the next few samples, so it knows how a run of flagged samples ends before it must emit the first of them:

- A run of one to three flagged samples becomes a straight line between the last emitted value and the next clean sample.
- A longer run fades the output toward zero by halving it once per sample.
- When clean data returns after a long run, the last three slots before the clean sample are rebuilt as a straight line. That line runs from the value emitted four slots earlier to the clean sample.

Each channel is an independent lane of the same logic.

Top module: `err_conceal`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and every bit of `out_sample` is 0.
- R2: `out_valid` is 1 exactly in the cycle after each cycle with `in_valid` = 1. In the cycle after a cycle with `in_valid` = 0, `out_valid` is 0 and `out_sample` keeps its previous value.
- R3: A sample whose flag is 0 appears unchanged on the output at the strobe that delivers the fourth later sample.
- R4: A run of L flagged samples (1 ≤ L ≤ 3) is emitted as P + i·trunc((S − P)/(L+1)) for i = 1..L. Here P is the output just before the run, S is the clean sample after it, and trunc rounds toward zero.
- R5: In a run of four or more flagged samples, each slot that is not one of the last three before the clean sample outputs the previous output divided by two, rounded toward zero. A full-scale value therefore reaches 0.
- R6: When a clean sample S follows a run of four or more, the three slots before it are emitted as Q + i·trunc((S − Q)/4) for i = 1..3. Here Q is the value emitted four slots before S.
- R7: Channel c uses bits [16c+15:16c] of the sample buses and bit c of `in_flag`. A channel's output depends only on that channel's inputs.
- R8: The delay line starts out holding four clean zeros. The first four outputs after reset are therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: one sample per channel is present |
| in_sample | input | 32 | Signed samples, channel c at bits [16c+15:16c] |
| in_flag | input | 2 | Uncorrectable-error flag, bit c for channel c |
| out_valid | output | 1 | Strobe: concealed samples are present |
| out_sample | output | 32 | Concealed signed samples, same layout as the input |

## Verification
The result for sample k is due one clock after the strobe that delivers sample k+4. The bench drives each strobe on a falling edge and reads the outputs on the next falling edge, checking them against a value for sample k that it computed arithmetically beforehand. Idle cycles are placed between strobes, and in each one the bench checks that `out_valid` is low and the outputs are unchanged. Every run length from one to seven is swept with full-scale, alternating-extreme, small and random endpoints. The two channels carry mirrored run lengths.

// File: rtl/conceal_pkg.sv
package conceal_pkg;
    // How the emitted value of one slot is formed.
    typedef enum logic [1:0] {
        PICK_PASS,   // clean sample goes straight through
        PICK_FILL,   // continue a line already started
        PICK_START,  // begin a line toward the next clean sample
        PICK_FADE    // halve toward zero
    } pick_e;
endpackage

// File: rtl/conceal_step.sv
module conceal_step #(
    parameter int W       = 16,
    parameter int MAX_RUN = 3
) (
    input  logic [W-1:0]                   from_val,
    input  logic [W-1:0]                   to_val,
    input  logic [$clog2(MAX_RUN+1)-1:0]   span,
    output logic [W:0]                     step
);
    localparam int DW = W + 1;
    localparam int CW = $clog2(MAX_RUN + 1);

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] quo [1:MAX_RUN];

    // sign-extended difference, wraps correctly in DW bits
    assign diff = {to_val[W-1], to_val} - {from_val[W-1], from_val};

    // one constant divisor per possible span
    for (genvar k = 1; k <= MAX_RUN; k++) begin : g_div
        assign quo[k] = diff / $signed(DW'(k + 1));
    end

    always_comb begin
        step = '0;
        for (int k = 1; k <= MAX_RUN; k++) begin
            if (span == CW'(k)) step = quo[k];
        end
    end
endmodule

// File: rtl/conceal_lane.sv
module conceal_lane
    import conceal_pkg::*;
#(
    parameter int W       = 16,
    parameter int MAX_RUN = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_sample,
    input  logic         in_flag,
    output logic [W-1:0] out_sample
);
    localparam int DEPTH = MAX_RUN + 1;
    localparam int CW    = $clog2(MAX_RUN + 1);
    localparam int DW    = W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] smp;   // index 0 is the next slot to emit
        logic [DEPTH-1:0]        flg;
        logic [W-1:0]            last;  // value emitted most recently
        logic [DW-1:0]           step;  // increment of the line in progress
        logic [CW-1:0]           left;  // slots of that line still to emit
    } lane_t;

    lane_t st_d, st_q;

    logic          found;
    logic [CW-1:0] ahead;
    logic [W-1:0]  target;
    logic [DW-1:0] step_new;
    logic [W-1:0]  fade_val;
    logic [W-1:0]  fade_pre;
    pick_e         pick;

    function automatic logic [W-1:0] clamp(input logic [DW-1:0] x);
        if (x[W] != x[W-1]) return x[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        return x[W-1:0];
    endfunction

    // nearest clean sample among the slots after the outgoing one
    always_comb begin
        found = 1'b0;
        ahead = '0;
        for (int k = MAX_RUN; k >= 1; k--) begin
            if (!st_q.flg[k]) begin
                found = 1'b1;
                ahead = CW'(k);
            end
        end
        target = st_q.smp[ahead];
    end

    conceal_step #(
        .W       (W),
        .MAX_RUN (MAX_RUN)
    ) i_step (
        .from_val (st_q.last),
        .to_val   (target),
        .span     (ahead),
        .step     (step_new)
    );

    // halve toward zero: bias negatives by one before the arithmetic shift
    assign fade_pre = st_q.last + W'(st_q.last[W-1]);
    assign fade_val = W'($signed(fade_pre) >>> 1);

    always_comb begin
        if (!st_q.flg[0])          pick = PICK_PASS;
        else if (st_q.left != '0)  pick = PICK_FILL;
        else if (found)            pick = PICK_START;
        else                       pick = PICK_FADE;
    end

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            unique case (pick)
                PICK_PASS: begin
                    st_d.last = st_q.smp[0];
                    st_d.left = '0;
                end
                PICK_FILL: begin
                    st_d.last = clamp({st_q.last[W-1], st_q.last} + st_q.step);
                    st_d.left = st_q.left - 1'b1;
                end
                PICK_START: begin
                    st_d.step = step_new;
                    st_d.last = clamp({st_q.last[W-1], st_q.last} + step_new);
                    st_d.left = ahead - 1'b1;
                end
                default: begin
                    st_d.last = fade_val;
                end
            endcase
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.smp[i] = st_q.smp[i+1];
                st_d.flg[i] = st_q.flg[i+1];
            end
            st_d.smp[DEPTH-1] = in_sample;
            st_d.flg[DEPTH-1] = in_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_sample = st_q.last;
endmodule

// File: rtl/err_conceal.sv
module err_conceal #(
    parameter int CH      = 2,
    parameter int W       = 16,
    parameter int MAX_RUN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CH*W-1:0] in_sample,
    input  logic [CH-1:0]   in_flag,
    output logic            out_valid,
    output logic [CH*W-1:0] out_sample
);
    logic vld_d, vld_q;

    for (genvar c = 0; c < CH; c++) begin : g_lane
        conceal_lane #(
            .W       (W),
            .MAX_RUN (MAX_RUN)
        ) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid),
            .in_sample  (in_sample[c*W +: W]),
            .in_flag    (in_flag[c]),
            .out_sample (out_sample[c*W +: W])
        );
    end

    always_comb begin
        vld_d = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
    end

    assign out_valid = vld_q;
endmodule

// File: rtl/err_conceal_chk.sv
module err_conceal_chk #(
    parameter int CH      = 2,
    parameter int W       = 16,
    parameter int MAX_RUN = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CH*W-1:0] in_sample,
    input logic [CH-1:0]   in_flag,
    input logic            out_valid,
    input logic [CH*W-1:0] out_sample
);
    localparam int DEPTH = MAX_RUN + 1;

    logic [DEPTH-1:0][W-1:0] hsmp [CH];
    logic [DEPTH-1:0]        hflg [CH];
    logic [W-1:0]            lane_out [CH];
    logic [W-1:0]            half_now [CH];

    // shadow history of accepted inputs, oldest at index 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++) begin
                hsmp[c] <= '0;
                hflg[c] <= '0;
            end
        end else if (in_valid) begin
            for (int c = 0; c < CH; c++) begin
                hsmp[c] <= {in_sample[c*W +: W], hsmp[c][DEPTH-1:1]};
                hflg[c] <= {in_flag[c], hflg[c][DEPTH-1:1]};
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sample))); // R2

    for (genvar g = 0; g < CH; g++) begin : g_lane
        assign lane_out[g] = out_sample[g*W +: W];
        always_comb half_now[g] = W'($signed(lane_out[g]) / 2);

        AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !hflg[g][0]) |=> (lane_out[g] == $past(hsmp[g][0]))); // R3

        AST_FADE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (&hflg[g])) |=> (lane_out[g] == $past(half_now[g]))); // R5
    end
endmodule

bind err_conceal err_conceal_chk #(
    .CH      (CH),
    .W       (W),
    .MAX_RUN (MAX_RUN)
) i_err_conceal_chk (.*);

// File: tb/test_err_conceal.sv
module test_err_conceal;
    localparam int CH   = 2;
    localparam int W    = 16;
    localparam int NMAX = 400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [CH*W-1:0] in_sample = '0;
    logic [CH-1:0]   in_flag = '0;
    logic            out_valid;
    logic [CH*W-1:0] out_sample;

    int          seq_s [CH][NMAX];
    bit          seq_f [CH][NMAX];
    int          pref  [CH][NMAX];
    int          kind  [CH][NMAX];
    int          tot;
    int          n_chk = 0;
    int          n_fail = 0;
    int unsigned rs = 32'h1234_5678;

    err_conceal #(.CH(CH), .W(W), .MAX_RUN(3)) i_err_conceal (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_flag    (in_flag),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string tag_name(input int code);
        case (code)
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7:       return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic rnd(output int v);
        logic signed [15:0] t;
        rs = rs * 32'd1664525 + 32'd1013904223;
        t  = rs[31:16];
        v  = t;
    endtask

    task automatic clean_val(input int mode, input int p, output int v);
        int r;
        rnd(r);
        case (mode)
            1:       v = 32767;
            2:       v = -32768;
            3:       v = (p % 2 == 1) ? 32767 : -32768;
            4:       v = r % 4;
            default: v = r;
        endcase
    endtask

    task automatic put(input int c, inout int p, input bit f, input int v);
        seq_s[c][p] = v;
        seq_f[c][p] = f;
        p++;
    endtask

    task automatic put_clean(input int c, inout int p, input int mode);
        int v;
        clean_val(mode, p, v);
        put(c, p, 1'b0, v);
    endtask

    task automatic put_bad(input int c, inout int p, input int n);
        int v;
        for (int i = 0; i < n; i++) begin
            rnd(v);
            put(c, p, 1'b1, v);
        end
    endtask

    task automatic build();
        for (int c = 0; c < CH; c++) begin
            int p = 0;
            for (int i = 0; i < 4; i++) put(c, p, 1'b0, 0);  // preloaded zeros (R8)
            for (int l = 1; l <= 7; l++) begin
                for (int mode = 0; mode < 6; mode++) begin
                    for (int i = 0; i < 3; i++) put_clean(c, p, mode);
                    put_bad(c, p, (c == 0) ? l : 8 - l);
                end
            end
            put(c, p, 1'b0, (c == 0) ? 32767 : -32768);
            put_bad(c, p, 20);                              // full fade to zero (R5)
            put_clean(c, p, 0); put_clean(c, p, 1);
            put_bad(c, p, 2); put_clean(c, p, 2);
            put_bad(c, p, 3); put_clean(c, p, 3);
            put_bad(c, p, 1); put_clean(c, p, 0);
            put_bad(c, p, 4); put_clean(c, p, 1);
            for (int i = 0; i < 8; i++) put_clean(c, p, 5);
            tot = p;
        end
    endtask

    // expected outputs straight from R3..R8
    task automatic model();
        for (int c = 0; c < CH; c++) begin
            for (int j = 0; j < tot; j++) begin
                if (j < 4) begin
                    pref[c][j] = 0; kind[c][j] = 8;
                end else if (!seq_f[c][j]) begin
                    pref[c][j] = seq_s[c][j]; kind[c][j] = 3;
                end else begin
                    int a = j;
                    int g = j;
                    int len;
                    while (seq_f[c][a-1]) a--;
                    while (seq_f[c][g]) g++;
                    len = g - a;
                    if (len <= 3) begin
                        pref[c][j] = pref[c][a-1] + (j - a + 1) * ((seq_s[c][g] - pref[c][a-1]) / (len + 1));
                        kind[c][j] = 4;
                    end else if (j >= g - 3) begin
                        pref[c][j] = pref[c][g-4] + (j - (g - 4)) * ((seq_s[c][g] - pref[c][g-4]) / 4);
                        kind[c][j] = 6;
                    end else begin
                        pref[c][j] = pref[c][j-1] / 2;
                        kind[c][j] = 5;
                    end
                end
            end
        end
    endtask

    task automatic check_lanes(input int j);
        for (int c = 0; c < CH; c++) begin
            logic signed [15:0] t;
            int code;
            t = out_sample[c*W +: W];
            code = kind[c][j];
            // R7: a lane whose flag differs from the other lane's checks independence
            if (c == 1 && seq_f[0][j] != seq_f[1][j]) code = 7;
            check(tag_name(code), t, pref[c][j]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        build();
        model();
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sample != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 4; k < tot; k++) begin
            in_valid = 1'b1;
            for (int c = 0; c < CH; c++) begin
                in_sample[c*W +: W] = W'(seq_s[c][k]);
                in_flag[c]          = seq_f[c][k];
            end
            @(negedge clk);
            check("R2", int'(out_valid), 1);
            check_lanes(k - 4);
            if (k % 7 == 3) begin
                in_valid  = 1'b0;
                in_sample = ~in_sample;
                in_flag   = ~in_flag;
                @(negedge clk);
                check("R2", int'(out_valid), 0);
                for (int c = 0; c < CH; c++) begin
                    logic signed [15:0] t;
                    t = out_sample[c*W +: W];
                    check("R2", t, pref[c][k-4]);
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        report();
    end
endmodule